// File: doc/BRIEF.md
# SPI Flash Master with Register Bank

This block is a single-select SPI master meant to sit in front of a serial flash. Software drives it through four word registers: a command register, a status register, a transmit word port and a receive word port. A transfer moves one word of 1 to 32 bits. Software pushes a word into the 4-deep transmit FIFO, writes the command register with the length, clock mode and enables, and sets the start bit in the same write.

The engine left-aligns the word and shifts it out most significant bit first. At the same time it shifts the bits on the input line into the low end of a capture register. When the last edge has passed, the engine pushes the captured word into the 4-deep receive FIFO and raises a sticky completion flag. Event flags in the status register stay set until software writes a one to them, so writing back a status value that was just read clears exactly the events that were seen.

The serial clock runs at the system clock divided by 2*SCK_HALF. The select line is either tied to the busy state or held by software through a value bit whose sense is inverted.

Top module: `sfm_master`

## Requirements
- R1: The offsets are command 0x00, status 0x04, transmit port 0x10 and receive port 0x20. Any other offset reads zero. After reset, command reads 0 and status reads 0x0280_0000, which means both FIFOs are empty and no flags are set.
- R2: Writing command bit 30 (start) while idle begins a transfer, and status bit 31 (busy) reads 1 from the next cycle. Bit 30 is never stored and always reads back as 0.
- R3: Command bits 4:0 hold the bit count minus one. Bit (count-1) of the word goes out first. The received bits fill the low end of the captured word, so with the input looped to the output the receive port returns the sent word masked to the count.
- R4: A transfer of N bits keeps busy high for exactly 2*N*SCK_HALF system cycles.
- R5: When a transfer ends, status bit 30 (ready) is set and stays set. Writing 0 to it has no effect, and writing 1 clears it.
- R6: Reading the receive port while the receive FIFO is empty returns 0 and sets sticky bit 27 (underrun). Bit 27 is cleared by writing 1 to it.
- R7: Writing the transmit port while the transmit FIFO is full (4 words) drops the word and sets sticky bit 26 (overflow). The words already in the FIFO are sent in the order they were written.
- R8: Command bit 12 set selects software select: command bit 13 = 1 drives the select line low and 0 drives it high. With bit 12 clear, the select line is low exactly while busy.
- R9: A start write issued while busy is ignored. No extra transmit word is consumed and no extra receive word is produced.
- R10: Command bit 26 sets the idle level of the serial clock. Command bit 18 chooses the edge: 0 samples on the leading edge, 1 samples on the trailing edge. Loopback holds in all four combinations.
- R11: With command bit 15 (transmit enable) clear, the output line stays low and the transmit FIFO is not popped. With command bit 14 (receive enable) clear, nothing is pushed to the receive FIFO.
- R12: Status bits 25, 24, 23 and 22 report receive empty, receive full, transmit empty and transmit full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive port) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low select |

## Verification
Read data is combinational, so the bench samples it in the same cycle the strobe is high, before the edge that pops the FIFO. Busy and the select line change on the edge that takes the start write, and they fall 2*N*SCK_HALF edges later. The bench counts falling edges while the select line is low and compares that count with the arithmetic value. The ready flag and the received word land one edge after busy falls. For that reason the bench polls status until busy reads 0 before it looks at the receive port. Sticky flags are checked in the cycle right after the access that set them.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   localparam int WORD_W = 32;
   localparam int LEN_W  = 5;
   localparam int ADDR_W = 6;

   localparam logic [ADDR_W-1:0] A_CMD  = 6'h00;
   localparam logic [ADDR_W-1:0] A_STAT = 6'h04;
   localparam logic [ADDR_W-1:0] A_TXP  = 6'h10;
   localparam logic [ADDR_W-1:0] A_RXP  = 6'h20;

   localparam int C_GO     = 30;
   localparam int C_CPOL   = 26;
   localparam int C_CPHA   = 18;
   localparam int C_TXEN   = 15;
   localparam int C_RXEN   = 14;
   localparam int C_CSVAL  = 13;
   localparam int C_CSSOFT = 12;

   localparam int S_BUSY  = 31;
   localparam int S_READY = 30;
   localparam int S_URUN  = 27;
   localparam int S_OVF   = 26;
   localparam int S_RXE   = 25;
   localparam int S_RXF   = 24;
   localparam int S_TXE   = 23;
   localparam int S_TXF   = 22;

   localparam logic [WORD_W-1:0] CMD_WMASK = 32'h0C0C_F01F;

   typedef struct packed {
      logic             cpol;
      logic             cpha;
      logic             txen;
      logic [LEN_W-1:0] last_bit;
   } shift_cfg_t;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $fatal(1, "sfm_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;

   wire do_push = push && !full;
   wire do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem[rp_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift
   import sfm_pkg::*;
#(
   parameter int HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  shift_cfg_t        cfg,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sck,
   output logic              mosi
);
   localparam int EDGE_W = LEN_W + 1;

   initial begin
      assert (HALF >= 1) else $fatal(1, "sfm_shift: HALF must be >= 1");
   end

   logic tick;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                div_q <= '0;
            else if (!busy || div_q == CW'(HALF - 1))  div_q <= '0;
            else                                       div_q <= div_q + 1'b1;
         end
         assign tick = busy && (div_q == CW'(HALF - 1));
      end
   endgenerate

   logic [EDGE_W-1:0] edge_q, last_q;
   logic              cpha_q, txen_q, sck_q;
   logic [WORD_W-1:0] sh_out, sh_in;

   // even edges are leading; phase picks which parity samples
   wire sample_now = (edge_q[0] == cpha_q);
   wire shift_now  = !sample_now && (edge_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         edge_q <= '0;
         last_q <= '0;
         cpha_q <= 1'b0;
         txen_q <= 1'b0;
         sck_q  <= 1'b0;
         sh_out <= '0;
         sh_in  <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy   <= 1'b1;
            edge_q <= '0;
            last_q <= {cfg.last_bit, 1'b1};
            cpha_q <= cfg.cpha;
            txen_q <= cfg.txen;
            sck_q  <= cfg.cpol;
            sh_out <= tx_word << (LEN_W'(WORD_W - 1) - cfg.last_bit);
            sh_in  <= '0;
         end else if (tick) begin
            sck_q <= ~sck_q;
            if (sample_now) sh_in  <= {sh_in[WORD_W-2:0], miso};
            if (shift_now)  sh_out <= {sh_out[WORD_W-2:0], 1'b0};
            if (edge_q == last_q) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               edge_q <= edge_q + 1'b1;
            end
         end
      end
   end

   assign rx_word = sh_in;
   assign sck     = sck_q;
   assign mosi    = busy && txen_q && sh_out[WORD_W-1];
endmodule

// File: rtl/sfm_master.sv
module sfm_master
   import sfm_pkg::*;
#(
   parameter int SCK_HALF   = 2,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);
   logic [WORD_W-1:0] cmd_q;
   logic              ready_q, urun_q, ovf_q;
   logic              busy, done, sh_sck;
   logic [WORD_W-1:0] rx_word, tx_head, rx_head, tx_word;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   shift_cfg_t        cfg;

   wire wr_cmd  = reg_wr && (reg_addr == A_CMD);
   wire wr_stat = reg_wr && (reg_addr == A_STAT);
   wire wr_txp  = reg_wr && (reg_addr == A_TXP);
   wire rd_rxp  = reg_rd && (reg_addr == A_RXP);

   wire go     = wr_cmd && reg_wdata[C_GO] && !busy;
   wire tx_pop = go && reg_wdata[C_TXEN] && !tx_empty;
   wire rx_pop = rd_rxp && !rx_empty;
   wire rx_psh = done && cmd_q[C_RXEN];

   assign cfg.cpol     = reg_wdata[C_CPOL];
   assign cfg.cpha     = reg_wdata[C_CPHA];
   assign cfg.txen     = reg_wdata[C_TXEN];
   assign cfg.last_bit = reg_wdata[LEN_W-1:0];
   assign tx_word      = tx_pop ? tx_head : '0;

   sfm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .push(wr_txp), .din(reg_wdata),
      .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

   sfm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .push(rx_psh), .din(rx_word),
      .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full));

   sfm_shift #(.HALF(SCK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(go), .cfg(cfg), .tx_word(tx_word),
      .miso(spi_miso), .busy(busy), .done(done), .rx_word(rx_word),
      .sck(sh_sck), .mosi(spi_mosi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         ready_q <= 1'b0;
         urun_q  <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (wr_cmd) cmd_q <= reg_wdata & CMD_WMASK;
         // a new event wins over a clear in the same cycle
         if (done)                              ready_q <= 1'b1;
         else if (wr_stat && reg_wdata[S_READY]) ready_q <= 1'b0;
         if (rd_rxp && rx_empty)                urun_q  <= 1'b1;
         else if (wr_stat && reg_wdata[S_URUN]) urun_q  <= 1'b0;
         if (wr_txp && tx_full)                 ovf_q   <= 1'b1;
         else if (wr_stat && reg_wdata[S_OVF])  ovf_q   <= 1'b0;
      end
   end

   logic [WORD_W-1:0] stat_word;
   always_comb begin
      stat_word          = '0;
      stat_word[S_BUSY]  = busy;
      stat_word[S_READY] = ready_q;
      stat_word[S_URUN]  = urun_q;
      stat_word[S_OVF]   = ovf_q;
      stat_word[S_RXE]   = rx_empty;
      stat_word[S_RXF]   = rx_full;
      stat_word[S_TXE]   = tx_empty;
      stat_word[S_TXF]   = tx_full;
   end

   always_comb begin
      case (reg_addr)
         A_CMD:   reg_rdata = cmd_q;
         A_STAT:  reg_rdata = stat_word;
         A_RXP:   reg_rdata = rx_empty ? '0 : rx_head;
         default: reg_rdata = '0;
      endcase
   end

   assign spi_sck  = busy ? sh_sck : cmd_q[C_CPOL];
   assign spi_cs_n = cmd_q[C_CSSOFT] ? ~cmd_q[C_CSVAL] : ~busy;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker
   import sfm_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [WORD_W-1:0] reg_wdata,
   input logic              spi_cs_n,
   input logic              busy,
   input logic              ready_q,
   input logic              urun_q,
   input logic              ovf_q,
   input logic              rx_empty,
   input logic              tx_full
);
   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CMD && reg_wdata[C_GO] && !busy) |=> busy); // R2

   AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> ready_q); // R5

   AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_RXP && rx_empty) |=> urun_q); // R6

   AST_NO_OVERFLOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXP && tx_full) |=> ovf_q); // R7

   AST_SOFT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CMD && reg_wdata[C_CSSOFT])
         |=> (spi_cs_n == !$past(reg_wdata[C_CSVAL]))); // R8
endmodule

bind sfm_master sfm_checker u_chk (.*);

// File: tb/sfm_master_tb.sv
module sfm_master_tb_top;
   localparam int HALF = 2;
   localparam logic [5:0] A_CMD = 6'h00, A_STAT = 6'h04, A_TXP = 6'h10, A_RXP = 6'h20;
   localparam logic [31:0] GO = 32'h4000_0000, TXEN = 32'h0000_8000, RXEN = 32'h0000_4000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic spi_sck, spi_mosi, spi_cs_n;

   int checks = 0, fails = 0, cyc = 0;

   always #5 clk = ~clk;

   sfm_master #(.SCK_HALF(HALF), .FIFO_DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_mosi),
      .spi_cs_n(spi_cs_n));

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STAT, s);
         if (!s[31]) break;
      end
   endtask

   task automatic clear_stat();
      logic [31:0] s;
      rd(A_STAT, s);
      wr(A_STAT, s);
   endtask

   function automatic logic [31:0] lenmask(input int n);
      return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
   endfunction

   task automatic loop_xfer(input string req, input int n, input bit cpol, input bit cpha,
                            input logic [31:0] w);
      logic [31:0] r, c;
      c = ({31'b0, cpol} << 26) | ({31'b0, cpha} << 18) | TXEN | RXEN | 32'(n - 1);
      wr(A_TXP, w);
      wr(A_CMD, c | GO);
      wait_idle();
      rd(A_RXP, r);
      chk(req, r, w & lenmask(n));
   endtask

   initial begin
      logic [31:0] v, s;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and map
      rd(A_STAT, v); chk("R1 status reset", v, 32'h0280_0000);
      rd(A_CMD, v);  chk("R1 command reset", v, 32'h0);
      rd(6'h08, v);  chk("R1 unmapped offset", v, 32'h0);
      chk("R8 select idle high", {31'b0, spi_cs_n}, 32'h1);

      // R3 every length, mode 0
      for (int len = 1; len <= 32; len++)
         loop_xfer("R3 loopback length", len, 1'b0, 1'b0, 32'h9E37_79B9 * 32'(len) + 32'h1357_0000);

      // R10 other modes at whole-byte lengths
      for (int m = 1; m < 4; m++) begin
         for (int b = 1; b <= 4; b++)
            loop_xfer("R10 loopback mode", 8 * b, m[1], m[0], 32'hC3A5_5A3C ^ (32'h0101_0101 * 32'(m + b)));
         @(negedge clk);
         chk("R10 idle clock level", {31'b0, spi_sck}, {31'b0, m[1]});
      end
      clear_stat();

      // R2 busy after start, start bit not stored
      wr(A_TXP, 32'h0000_00A7);
      wr(A_CMD, TXEN | RXEN | 32'd7 | GO);
      rd(A_STAT, v); chk("R2 busy after start", {31'b0, v[31]}, 32'h1);
      rd(A_CMD, v);  chk("R2 start bit reads 0", {31'b0, v[30]}, 32'h0);
      wait_idle();
      rd(A_RXP, v);  chk("R3 byte readback", v, 32'h0000_00A7);

      // R5 ready sticky and write-one-to-clear
      rd(A_STAT, v); chk("R5 ready set", {31'b0, v[30]}, 32'h1);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R5 ready kept on write 0", {31'b0, v[30]}, 32'h1);
      wr(A_STAT, 32'h4000_0000);
      rd(A_STAT, v); chk("R5 ready cleared", {31'b0, v[30]}, 32'h0);

      // R4 busy window via hardware select
      wr(A_TXP, 32'h5A);
      wr(A_CMD, TXEN | RXEN | 32'd7 | GO);
      n = 0;
      while (spi_cs_n == 1'b0 && n < 1000) begin n++; @(negedge clk); end
      chk("R4 busy cycles for 8 bits", 32'(n), 32'(2 * 8 * HALF));
      wait_idle();
      rd(A_RXP, v);

      // R6 underrun
      rd(A_RXP, v);  chk("R6 empty read returns 0", v, 32'h0);
      rd(A_STAT, v); chk("R6 underrun set", {31'b0, v[27]}, 32'h1);
      wr(A_STAT, v);
      rd(A_STAT, v); chk("R6 underrun cleared", {31'b0, v[27]}, 32'h0);

      // R7 / R12 overflow and flags
      for (int i = 0; i < 5; i++) wr(A_TXP, 32'h1000_0000 * 32'(i + 1) + 32'h77);
      rd(A_STAT, v);
      chk("R12 tx full flag", {31'b0, v[22]}, 32'h1);
      chk("R7 overflow set", {31'b0, v[26]}, 32'h1);
      for (int i = 0; i < 4; i++) begin
         wr(A_CMD, TXEN | RXEN | 32'd31 | GO);
         wait_idle();
      end
      rd(A_STAT, v);
      chk("R12 rx full flag", {31'b0, v[24]}, 32'h1);
      chk("R12 tx empty flag", {31'b0, v[23]}, 32'h1);
      for (int i = 0; i < 4; i++) begin
         rd(A_RXP, v); chk("R7 order of kept words", v, 32'h1000_0000 * 32'(i + 1) + 32'h77);
      end
      rd(A_STAT, v); chk("R12 rx empty flag", {31'b0, v[25]}, 32'h1);
      clear_stat();

      // R9 start while busy
      wr(A_TXP, 32'h0000_1234);
      wr(A_TXP, 32'h0000_5678);
      wr(A_CMD, TXEN | RXEN | 32'd15 | GO);
      wr(A_CMD, TXEN | RXEN | 32'd15 | GO);
      wait_idle();
      rd(A_STAT, v); chk("R9 second word kept", {31'b0, v[23]}, 32'h0);
      rd(A_RXP, v);  chk("R9 first word", v, 32'h0000_1234);
      rd(A_RXP, v);  chk("R9 only one rx word", v, 32'h0);
      wr(A_CMD, TXEN | RXEN | 32'd15 | GO);
      wait_idle();
      rd(A_RXP, v);  chk("R9 second word later", v, 32'h0000_5678);
      clear_stat();

      // R11 enables
      wr(A_TXP, 32'h0000_00FF);
      wr(A_CMD, RXEN | 32'd7 | GO);
      wait_idle();
      rd(A_RXP, v);  chk("R11 no tx drives low", v, 32'h0);
      rd(A_STAT, v); chk("R11 tx not popped", {31'b0, v[23]}, 32'h0);
      wr(A_CMD, TXEN | 32'd7 | GO);
      wait_idle();
      rd(A_STAT, s);
      chk("R11 no rx push", {31'b0, s[25]}, 32'h1);
      chk("R11 tx popped", {31'b0, s[23]}, 32'h1);

      // R8 software select
      wr(A_CMD, 32'h0000_3000);
      @(negedge clk); chk("R8 soft value 1 -> low", {31'b0, spi_cs_n}, 32'h0);
      wr(A_CMD, 32'h0000_1000);
      @(negedge clk); chk("R8 soft value 0 -> high", {31'b0, spi_cs_n}, 32'h1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule